// File: doc/BRIEF.md
# DMA Channel Enable and Completion Control

This block is the control side of a single DMA channel. It holds the channel's enable and mask bits, a transfer-end flag and a transfer count. From the request mode, a chip-wide master enable and two abort inputs (NMI and address error), it decides each cycle whether the channel may move data, and it asserts `active` while a transfer is allowed and a request is present. The datapath that does the moves returns one `xfer_done` strobe for each transfer. Each strobe that arrives while the channel is active lowers the count by one.

Software reaches the block through a small register port. Address 0 holds the count. Address 1 is the control/status word: bit 0 is the channel enable, bit 1 is the end flag and bit 2 is the end-flag mask. The end flag is set only when the count runs out. It can be cleared only by writing 0 to it after a read has returned it as 1. The mask lets level-detected external requests and peripheral requests run while the flag is still set. Edge-detected requests are always held off by a set flag.

Top module: `dma_chan_ctl`

## Requirements
- R1: Address 0 reads and writes the count. Address 1 reads `{mask, flag, enable}` in bits 2..0 and writes enable from bit 0 and mask from bit 2. Any other address reads 0. After reset every bit is 0 and `active` is 0.
- R2: An `xfer_done` in a cycle where `active` is 1 and the count is not 0 lowers the count by one at the next edge. A count write in the same cycle takes precedence.
- R3: A decrement that takes the count from 1 to 0 sets the end flag and clears `active` at the same edge.
- R4: The end flag stays 0 when a transfer is cut short by NMI, address error, clearing the channel enable or clearing the master enable.
- R5: Writing 0 to flag bit 1 clears the flag only if a read of address 1 (`reg_rd`) returned the flag as 1 after the flag was last set. Writing 1 to bit 1 never changes the flag.
- R6: In auto mode (`mode` = 00), `active` is 1 one edge after a cycle in which the enable, master enable and a non-zero count are present and the flag, NMI and address error are all 0.
- R7: In external-level mode (01) and peripheral mode (11), `active` follows `req` one edge late. The end flag is ignored when the mask is 1.
- R8: In external-edge mode (10), a rising edge of `req` starts a run that continues with `req` low until the count ends or permission is lost. A set end flag blocks it whatever the mask.
- R9: With mask 0 and the flag at 1, setting the enable does not make `active` rise.
- R10: `active` falls at the first edge at which the enable is 0 or master enable is 0, or NMI or address error is 1.
- R11: A count of 0 never lets `active` rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms the flag clear) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| mode | input | 2 | Request mode: 00 auto, 01 ext level, 10 ext edge, 11 peripheral |
| req | input | 1 | External or peripheral request |
| master_en | input | 1 | Chip-wide DMA master enable |
| nmi_flag | input | 1 | NMI abort flag |
| addr_err | input | 1 | Address-error abort flag |
| xfer_done | input | 1 | One transfer completed by the datapath |
| active | output | 1 | Channel may transfer now |
| end_flag | output | 1 | Transfer-end flag |

## Verification
Every register changes at the clock edge that samples the stimulus. `reg_rdata` is combinational, so a count or control write shows up at the next edge. `active` and the end flag are registered: a change in enable, mode, request or abort inputs shows on `active` one edge later, and the final decrement drops `active` and raises the flag at that same edge. The bench drives inputs 2 ns after each rising edge and compares every output with its reference model at that point, so each result is checked in the cycle it is due.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO   = 2'b00,
    MODE_LEVEL  = 2'b01,
    MODE_EDGE   = 2'b10,
    MODE_PERIPH = 2'b11
  } req_mode_e;

  localparam int unsigned ADDR_COUNT   = 0;
  localparam int unsigned ADDR_CTRL    = 1;
  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_END_BIT  = 1;
  localparam int unsigned CTL_MASK_BIT = 2;

  // the end flag holds the channel off unless masked in a level-type mode
  function automatic logic flag_blocks(logic flag, logic mask, req_mode_e m);
    logic level_type;
    level_type = (m == MODE_LEVEL) || (m == MODE_PERIPH);
    return flag && !(mask && level_type);
  endfunction

endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect
  import dma_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  req_mode_e mode,
  input  logic      req,
  input  logic      permit,
  input  logic      end_hit,
  output logic      req_present
);

  logic req_q;
  logic run_q;
  logic rise;

  assign rise = req && !req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      req_q <= req;
      run_q <= (mode == MODE_EDGE) && permit && !end_hit && (run_q || rise);
    end
  end

  always_comb begin
    unique case (mode)
      MODE_AUTO:  req_present = 1'b1;
      MODE_EDGE:  req_present = run_q || rise;
      default:    req_present = req;
    endcase
  end

endmodule

// File: rtl/dma_permit.sv
module dma_permit
  import dma_chan_pkg::*;
(
  input  req_mode_e mode,
  input  logic      chan_en,
  input  logic      master_en,
  input  logic      nmi_flag,
  input  logic      addr_err,
  input  logic      end_flag,
  input  logic      mask,
  input  logic      cnt_nz,
  output logic      permit
);

  logic aborted;

  assign aborted = nmi_flag || addr_err;
  assign permit  = chan_en && master_en && !aborted && cnt_nz
                   && !flag_blocks(end_flag, mask, mode);

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              dec_req,
  output logic              chan_en,
  output logic              mask,
  output logic              end_flag,
  output logic              armed,
  output logic [CNT_W-1:0]  cnt,
  output logic              cnt_nz,
  output logic              dec_ok,
  output logic              end_hit
);

  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(ADDR_COUNT);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ADDR_CTRL);
  localparam logic [CNT_W-1:0]  ONE   = CNT_W'(1);

  function automatic logic [CNT_W-1:0] count_after(logic [CNT_W-1:0] c,
                                                   logic load,
                                                   logic [CNT_W-1:0] val,
                                                   logic step);
    if (load)      return val;
    else if (step) return c - ONE;
    else           return c;
  endfunction

  logic wr_cnt, wr_ctl, clr_ok, arm_hit;

  assign wr_cnt  = reg_wr && (reg_addr == A_CNT);
  assign wr_ctl  = reg_wr && (reg_addr == A_CTL);
  assign cnt_nz  = (cnt != '0);
  assign dec_ok  = dec_req && cnt_nz && !wr_cnt;
  assign end_hit = dec_ok && (cnt == ONE);
  assign clr_ok  = wr_ctl && !reg_wdata[CTL_END_BIT] && armed && end_flag;
  assign arm_hit = reg_rd && (reg_addr == A_CTL) && end_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      chan_en  <= 1'b0;
      mask     <= 1'b0;
      end_flag <= 1'b0;
      armed    <= 1'b0;
    end else begin
      cnt <= count_after(cnt, wr_cnt, reg_wdata[CNT_W-1:0], dec_ok);
      if (wr_ctl) begin
        chan_en <= reg_wdata[CTL_EN_BIT];
        mask    <= reg_wdata[CTL_MASK_BIT];
      end
      if (end_hit)     end_flag <= 1'b1;
      else if (clr_ok) end_flag <= 1'b0;
      if (end_hit || clr_ok) armed <= 1'b0;
      else if (arm_hit)      armed <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CNT) begin
      reg_rdata = DATA_W'(cnt);
    end else if (reg_addr == A_CTL) begin
      reg_rdata[CTL_EN_BIT]   = chan_en;
      reg_rdata[CTL_END_BIT]  = end_flag;
      reg_rdata[CTL_MASK_BIT] = mask;
    end
  end

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [1:0]        mode,
  input  logic              req,
  input  logic              master_en,
  input  logic              nmi_flag,
  input  logic              addr_err,
  input  logic              xfer_done,
  output logic              active,
  output logic              end_flag
);

  req_mode_e          mode_e;
  logic               chan_en, mask_q, armed, cnt_nz;
  logic               dec_req, dec_ok, end_hit;
  logic               permit, req_present;
  logic [CNT_W-1:0]   cnt_q;

  assign mode_e  = req_mode_e'(mode);
  assign dec_req = xfer_done && active;

  dma_chan_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .dec_req   (dec_req),
    .chan_en   (chan_en),
    .mask      (mask_q),
    .end_flag  (end_flag),
    .armed     (armed),
    .cnt       (cnt_q),
    .cnt_nz    (cnt_nz),
    .dec_ok    (dec_ok),
    .end_hit   (end_hit)
  );

  dma_permit u_permit (
    .mode      (mode_e),
    .chan_en   (chan_en),
    .master_en (master_en),
    .nmi_flag  (nmi_flag),
    .addr_err  (addr_err),
    .end_flag  (end_flag),
    .mask      (mask_q),
    .cnt_nz    (cnt_nz),
    .permit    (permit)
  );

  dma_req_detect u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_e),
    .req         (req),
    .permit      (permit),
    .end_hit     (end_hit),
    .req_present (req_present)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) active <= 1'b0;
    else        active <= permit && req_present && !end_hit;
  end

endmodule

// File: rtl/dma_chan_ctl_checker.sv
module dma_chan_ctl_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             master_en,
  input logic             nmi_flag,
  input logic             addr_err,
  input logic             active,
  input logic             end_flag,
  input logic             chan_en,
  input logic             mask_q,
  input logic             armed,
  input logic             dec_ok,
  input logic             end_hit,
  input logic [CNT_W-1:0] cnt_q
);

  p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dec_ok |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_flag_from_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_flag) |-> $past(end_hit));

  p_end_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |=> !active);

  p_clear_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(end_flag) |-> $past(armed));

  p_edge_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10 && end_flag) |=> !active);

  p_unmasked_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_flag && !mask_q) |=> !active);

  p_abort_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_flag || addr_err || !master_en || !chan_en) |=> !active);

  p_zero_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |=> !active);

endmodule

bind dma_chan_ctl dma_chan_ctl_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .master_en (master_en),
  .nmi_flag  (nmi_flag),
  .addr_err  (addr_err),
  .active    (active),
  .end_flag  (end_flag),
  .chan_en   (chan_en),
  .mask_q    (mask_q),
  .armed     (armed),
  .dec_ok    (dec_ok),
  .end_hit   (end_hit),
  .cnt_q     (cnt_q)
);

// File: tb/test_dma_chan_ctl.sv
`timescale 1ns/1ps
module test_dma_chan_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [1:0]  mode = 2'b00;
  logic        req = 1'b0, master_en = 1'b0, nmi_flag = 1'b0, addr_err = 1'b0;
  logic        xfer_done = 1'b0;
  logic        active, end_flag;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_chan_ctl i_dma_chan_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mode(mode), .req(req), .master_en(master_en), .nmi_flag(nmi_flag),
    .addr_err(addr_err), .xfer_done(xfer_done), .active(active),
    .end_flag(end_flag)
  );

  // behavioural reference state
  logic [31:0] m_cnt;
  bit m_en, m_mask, m_flag, m_read_seen, m_act, m_prev_req, m_edge_run;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_mask = 0; m_flag = 0; m_read_seen = 0;
      m_act = 0; m_prev_req = 0; m_edge_run = 0;
    end else begin
      bit may_go, has_req, edge_seen, cnt_load, ctl_load, step, last, do_clr, do_arm;
      bit flag_ok;
      flag_ok   = !m_flag || (m_mask && (mode == 2'b01 || mode == 2'b11));
      may_go    = m_en && master_en && !nmi_flag && !addr_err && (m_cnt != 0) && flag_ok;
      edge_seen = req && !m_prev_req;
      if (mode == 2'b00)      has_req = 1;
      else if (mode == 2'b10) has_req = m_edge_run || edge_seen;
      else                    has_req = req;
      cnt_load = reg_wr && reg_addr == 2'd0;
      ctl_load = reg_wr && reg_addr == 2'd1;
      step     = xfer_done && m_act && (m_cnt != 0) && !cnt_load;
      last     = step && (m_cnt == 1);
      do_clr   = ctl_load && !reg_wdata[1] && m_read_seen && m_flag;
      do_arm   = reg_rd && reg_addr == 2'd1 && m_flag;
      m_act      = may_go && has_req && !last;
      m_edge_run = (mode == 2'b10) && may_go && !last && (m_edge_run || edge_seen);
      m_prev_req = req;
      if (cnt_load) m_cnt = reg_wdata;
      else if (step) m_cnt = m_cnt - 1;
      if (ctl_load) begin m_en = reg_wdata[0]; m_mask = reg_wdata[2]; end
      if (last || do_clr) m_read_seen = 0;
      else if (do_arm)    m_read_seen = 1;
      if (last) m_flag = 1;
      else if (do_clr) m_flag = 0;
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rdata();
    if (reg_addr == 2'd0) return m_cnt;
    if (reg_addr == 2'd1) return {29'd0, m_mask, m_flag, m_en};
    return 32'd0;
  endfunction

  // one clock: advance, then compare everything 2 ns after the edge
  task automatic tick();
    @(posedge clk);
    #2;
    check("R6/R7/R8 active", {31'd0, active}, {31'd0, m_act});
    check("R3 end_flag", {31'd0, end_flag}, {31'd0, m_flag});
    check("R1 rdata", reg_rdata, model_rdata());
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic rd_ctl();
    reg_rd = 1; reg_addr = 2'd1;
    tick();
    reg_rd = 0;
  endtask

  task automatic done_pulses(int n);
    xfer_done = 1;
    idle(n);
    xfer_done = 0;
  endtask

  task automatic clear_flag(logic [31:0] ctl);
    rd_ctl();
    wr(2'd1, ctl & 32'hFFFF_FFFD);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    reg_addr = 2'd1;
    tick();
    check("R1 reset ctrl", reg_rdata, 32'd0);
    check("R1 reset active", {31'd0, active}, 32'd0);

    // R1/R2/R3/R6: auto-mode run of three transfers
    wr(2'd0, 32'd3);
    reg_addr = 2'd0;
    #1 check("R1 count readback", reg_rdata, 32'd3);
    master_en = 1; mode = 2'b00;
    wr(2'd1, 32'd1);
    check("R6 active one edge late", {31'd0, active}, 32'd0);
    tick();
    check("R6 auto active", {31'd0, active}, 32'd1);
    reg_addr = 2'd0;
    done_pulses(2);
    check("R2 count after two", reg_rdata, 32'd1);
    done_pulses(1);
    check("R3 count zero", reg_rdata, 32'd0);
    check("R3 flag set", {31'd0, end_flag}, 32'd1);
    check("R3 stopped", {31'd0, active}, 32'd0);

    // R9/R5: reload with flag set, enable does not start; clear needs read
    wr(2'd0, 32'd2);
    wr(2'd1, 32'd1);
    idle(2);
    check("R9 blocked by flag", {31'd0, active}, 32'd0);
    wr(2'd1, 32'd3);
    check("R5 write one keeps flag", {31'd0, end_flag}, 32'd1);
    wr(2'd1, 32'd1);
    check("R5 clear without read ignored", {31'd0, end_flag}, 32'd1);
    clear_flag(32'd1);
    check("R5 clear after read", {31'd0, end_flag}, 32'd0);
    tick();
    check("R6 restart after clear", {31'd0, active}, 32'd1);

    // R4/R10: abort paths do not set the flag
    nmi_flag = 1; tick();
    check("R10 nmi drop", {31'd0, active}, 32'd0);
    nmi_flag = 0; idle(2);
    addr_err = 1; tick();
    check("R10 addr err drop", {31'd0, active}, 32'd0);
    addr_err = 0; idle(2);
    master_en = 0; tick();
    check("R10 master drop", {31'd0, active}, 32'd0);
    master_en = 1; idle(2);
    wr(2'd1, 32'd0);
    tick();
    check("R10 enable clear drop", {31'd0, active}, 32'd0);
    check("R4 no flag on abort", {31'd0, end_flag}, 32'd0);

    // R7: level mode, mask lets flag be ignored
    mode = 2'b01; req = 1;
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd5);
    idle(2);
    done_pulses(1);
    check("R3 level end flag", {31'd0, end_flag}, 32'd1);
    wr(2'd0, 32'd4);
    idle(2);
    check("R7 masked flag ignored", {31'd0, active}, 32'd1);
    req = 0; tick();
    check("R7 follows req", {31'd0, active}, 32'd0);
    mode = 2'b11; req = 1; idle(2);
    check("R7 peripheral req", {31'd0, active}, 32'd1);
    req = 0; idle(2);

    // R8: edge mode blocked by flag even when masked, then runs on an edge
    mode = 2'b10;
    req = 1; idle(2); req = 0; idle(2);
    check("R8 flag blocks edge", {31'd0, active}, 32'd0);
    clear_flag(32'd5);
    idle(2);
    check("R8 no edge no run", {31'd0, active}, 32'd0);
    req = 1; tick(); req = 0; idle(3);
    check("R8 run persists", {31'd0, active}, 32'd1);
    done_pulses(6);
    check("R8 run ends", {31'd0, end_flag}, 32'd1);

    // R11: zero count never activates
    mode = 2'b00;
    clear_flag(32'd1);
    wr(2'd0, 32'd0);
    idle(3);
    check("R11 zero count idle", {31'd0, active}, 32'd0);
    idle(2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule